// File: doc/BRIEF.md
# Network Controller Command and Interrupt Unit

This block is the command and interrupt front end of a small Ethernet controller. Software reaches it through a byte-wide register port. A write to the command register can start or stop the controller, request a frame transmission, issue a remote DMA operation and select which register page later accesses reach. The transmit, receive and DMA datapaths sit outside the block. They report to it through busy levels and single-cycle event pulses.

Event pulses are caught in sticky status bits. Software clears a status bit by writing a 1 to its position. One interrupt line is raised whenever a status bit is set and its mask bit is also set. The top status bit works as a reset indicator. It is read-only, and it stays set while the controller is halted or a receive-ring overwrite has not yet been recovered. A stop request does not cut off a frame that is still in flight. The controller first drains: it halts only once both the transmit and receive sides are idle.

Every port is a plain control or status pin. No stream passes through the block, so no valid/ready handshake is needed.

Top module: `nic_cmd_irq`

## Requirements
- R1: After reset the controller is halted (`halted`=1). The command register reads 0x21: stop bit 0 set, start bit 1 clear, transmit-request bit 2 clear, DMA field bits 5:3 = 100, page bits 7:6 = 00. The status register reads 0x80, the mask reads 0x00, `irq`=0, `tx_req`=0 and `page`=0.
- R2: A command write with bit 0 set is a stop request. It halts the controller at the first clock edge at which `tx_busy` and `rx_busy` are both low. Until then, `halted` stays 0 and the command register reads bit 0 = 1 and bit 1 = 0. When the controller is running, bit 1 reads 1 and bit 0 reads 0.
- R3: A command write with bit 1 set and bit 0 clear is a start request. It returns the controller to running at the next edge, even during a drain. It also clears status bit 7, unless an overwrite event arrives in the same cycle. If bits 0 and 1 are both set, the stop request wins.
- R4: Status bit 7 reads as (halted OR overwrite pending). An `evt_in[4]` pulse sets the overwrite pending flag. A `ring_pop` pulse or a start request clears it, but a new event in the same cycle wins. Writes to status bit 7 have no effect.
- R5: Writing command bit 2 = 1 sets `tx_req`. A `tx_end` pulse clears it, but a set in the same cycle wins. Writing bit 2 = 0 leaves `tx_req` unchanged.
- R6: Command bits 5:3 hold the remote DMA code. 001 is read, 010 is write and 011 is send. A code with bit 5 set aborts. Any non-zero code is stored and shown on `dma_op`. The illegal code 000 is ignored. One cycle after a write, `dma_go` pulses for codes 001 to 011 and `dma_abort` pulses for codes 1xx.
- R7: Command bits 7:6 select register page 0, 1 or 2, shown on `page`. The reserved code 11 is ignored and the previous page is kept.
- R8: Status bits 0 to 6 are set by `evt_in[0..6]` in this order: receive OK, transmit OK, receive error, transmit error, ring overwrite, counter overflow, remote DMA done. They are visible one edge after the pulse.
- R9: A write to the status register clears every bit 0 to 6 whose written value is 1 and leaves the other bits unchanged. An event in the same cycle keeps its bit set.
- R10: Mask bits 0 to 6 can be written and read at the mask register, in the same order as the status bits. Mask bit 7 always reads 0.
- R11: `irq` is the OR over bits 0 to 6 of (status AND mask). It follows a status or mask change in the cycle after the edge that makes the change.
- R12: The command register sits at offset 0 on every page. Status (offset 1) and mask (offset 2) exist only on page 0. All other reads return 0, and status or mask writes made while the page is not 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset within the current page |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_busy | input | 1 | Transmit side has a frame in flight |
| rx_busy | input | 1 | Receive side has a frame in flight |
| tx_end | input | 1 | Pulse: transmission completed or aborted |
| ring_pop | input | 1 | Pulse: a packet was removed from the receive ring |
| evt_in | input | 7 | Event pulses, one per status bit 0 to 6 |
| irq | output | 1 | Interrupt request |
| halted | output | 1 | Controller is in the halted state |
| tx_req | output | 1 | Transmit request pending |
| dma_op | output | 3 | Stored remote DMA code |
| dma_go | output | 1 | Pulse: a remote DMA read, write or send was issued |
| dma_abort | output | 1 | Pulse: a remote DMA abort was issued |
| page | output | 2 | Selected register page |

## Verification
Directed sequences drive the stop request under held busy levels, and then with idle sides. This separates a stop that drains from one that halts at once. They also make an overwrite that overlaps a start, so that the two sources of status bit 7 can be told apart. Corner writes cover the illegal DMA code, the reserved page code, a 1 written to the read-only status bit, and status or mask writes made from a page other than 0. These show that ignored fields really leave the state alone. A long constrained-random phase then mixes sparse events, busy levels that persist for several cycles, and writes of random bytes to random offsets. Every output and every readable register is compared each cycle against a bench model. This exposes collisions between a set and a clear in the same cycle, which directed tests seldom reach.

// File: rtl/nic_cmd_irq_pkg.sv
package nic_cmd_irq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } run_state_e;

  localparam int EV_N = 7;
  localparam logic [2:0] DMA_ILLEGAL = 3'b000;
  localparam logic [2:0] DMA_IDLE    = 3'b100;
  localparam logic [1:0] PAGE_RSVD   = 2'b11;
endpackage

// File: rtl/nic_reg_port.sv
module nic_reg_port #(
  parameter int ADDR_W   = 4,
  parameter int OFS_CMD  = 0,
  parameter int OFS_STAT = 1,
  parameter int OFS_MASK = 2
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        page,
  input  logic [7:0]        cmd_rd,
  input  logic [7:0]        stat_rd,
  input  logic [7:0]        mask_rd,
  output logic              wr_cmd,
  output logic              wr_stat,
  output logic              wr_mask,
  output logic [7:0]        reg_rdata
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic pg0;
  logic hit_cmd, hit_stat, hit_mask;

  assign pg0      = (page == 2'd0);
  assign hit_cmd  = (reg_addr == A_CMD);
  assign hit_stat = pg0 && (reg_addr == A_STAT);
  assign hit_mask = pg0 && (reg_addr == A_MASK);

  assign wr_cmd  = reg_wr && hit_cmd;
  assign wr_stat = reg_wr && hit_stat;
  assign wr_mask = reg_wr && hit_mask;

  always_comb begin
    reg_rdata = 8'h00;
    if (hit_cmd)       reg_rdata = cmd_rd;
    else if (hit_stat) reg_rdata = stat_rd;
    else if (hit_mask) reg_rdata = mask_rd;
  end
endmodule

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
  import nic_cmd_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic [7:0] wdata,
  input  logic       tx_busy,
  input  logic       rx_busy,
  input  logic       tx_end,
  input  logic       ring_pop,
  input  logic       ovw_ev,
  output logic       halted,
  output logic       rst_flag,
  output logic       tx_req,
  output logic [2:0] dma_op,
  output logic       dma_go,
  output logic       dma_abort,
  output logic [1:0] page,
  output logic [7:0] cmd_rd
);
  run_state_e state, state_n;
  logic       ovw_pend;
  logic       stop_w, start_w, idle;
  logic [2:0] code;
  logic [1:0] pg_code;

  assign stop_w  = wr_cmd && wdata[0];
  assign start_w = wr_cmd && wdata[1] && !wdata[0];
  assign idle    = !tx_busy && !rx_busy;
  assign code    = wdata[5:3];
  assign pg_code = wdata[7:6];

  always_comb begin
    state_n = state;
    if (stop_w) begin
      if (idle || state == ST_HALT) state_n = ST_HALT;
      else                          state_n = ST_DRAIN;
    end else if (start_w) begin
      state_n = ST_RUN;
    end else if (state == ST_DRAIN && idle) begin
      state_n = ST_HALT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HALT;
      ovw_pend  <= 1'b0;
      tx_req    <= 1'b0;
      dma_op    <= DMA_IDLE;
      dma_go    <= 1'b0;
      dma_abort <= 1'b0;
      page      <= 2'd0;
    end else begin
      state <= state_n;
      if (ovw_ev)                    ovw_pend <= 1'b1;
      else if (start_w || ring_pop)  ovw_pend <= 1'b0;
      if (wr_cmd && wdata[2])        tx_req <= 1'b1;
      else if (tx_end)               tx_req <= 1'b0;
      if (wr_cmd && code != DMA_ILLEGAL) dma_op <= code;
      dma_go    <= wr_cmd && !code[2] && (code != DMA_ILLEGAL);
      dma_abort <= wr_cmd && code[2];
      if (wr_cmd && pg_code != PAGE_RSVD) page <= pg_code;
    end
  end

  assign halted   = (state == ST_HALT);
  assign rst_flag = halted || ovw_pend;
  assign cmd_rd   = {page, dma_op, tx_req, state == ST_RUN, state != ST_RUN};

  p_halt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(!tx_busy && !rx_busy));
  p_start_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !ovw_ev) |=> !rst_flag);
  p_ovw_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovw_ev |=> rst_flag);
  p_txreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_end) |=> tx_req);
  p_dma_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_go, dma_abort}));
  p_page_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page != PAGE_RSVD);
endmodule

// File: rtl/nic_int_unit.sv
module nic_int_unit
  import nic_cmd_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] evt,
  input  logic            wr_stat,
  input  logic            wr_mask,
  input  logic [EV_N-1:0] wdata,
  input  logic            rst_flag,
  output logic [7:0]      stat_rd,
  output logic [7:0]      mask_rd,
  output logic            irq
);
  logic [EV_N-1:0] stat, mask;

  for (genvar i = 0; i < EV_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat[i] <= 1'b0;
        mask[i] <= 1'b0;
      end else begin
        if (evt[i])                    stat[i] <= 1'b1;
        else if (wr_stat && wdata[i])  stat[i] <= 1'b0;
        if (wr_mask)                   mask[i] <= wdata[i];
      end
    end
  end

  assign irq     = |(stat & mask);
  assign stat_rd = {rst_flag, stat};
  assign mask_rd = {1'b0, mask};

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat & $past(wdata & ~evt)) == '0));
  p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/nic_cmd_irq.sv
module nic_cmd_irq
  import nic_cmd_irq_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OFS_CMD  = 0,
  parameter int OFS_STAT = 1,
  parameter int OFS_MASK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tx_busy,
  input  logic              rx_busy,
  input  logic              tx_end,
  input  logic              ring_pop,
  input  logic [EV_N-1:0]   evt_in,
  output logic              irq,
  output logic              halted,
  output logic              tx_req,
  output logic [2:0]        dma_op,
  output logic              dma_go,
  output logic              dma_abort,
  output logic [1:0]        page
);
  localparam int OVW_BIT = 4;

  logic       wr_cmd, wr_stat, wr_mask;
  logic       rst_flag;
  logic [7:0] cmd_rd, stat_rd, mask_rd;

  nic_reg_port #(
    .ADDR_W(ADDR_W), .OFS_CMD(OFS_CMD), .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK)
  ) u_port (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .page(page),
    .cmd_rd(cmd_rd), .stat_rd(stat_rd), .mask_rd(mask_rd),
    .wr_cmd(wr_cmd), .wr_stat(wr_stat), .wr_mask(wr_mask),
    .reg_rdata(reg_rdata)
  );

  nic_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(reg_wdata),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_end(tx_end),
    .ring_pop(ring_pop), .ovw_ev(evt_in[OVW_BIT]),
    .halted(halted), .rst_flag(rst_flag), .tx_req(tx_req),
    .dma_op(dma_op), .dma_go(dma_go), .dma_abort(dma_abort),
    .page(page), .cmd_rd(cmd_rd)
  );

  nic_int_unit u_int (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .wr_stat(wr_stat),
    .wr_mask(wr_mask), .wdata(reg_wdata[EV_N-1:0]), .rst_flag(rst_flag),
    .stat_rd(stat_rd), .mask_rd(mask_rd), .irq(irq)
  );

  p_drain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && (tx_busy || rx_busy) && !reg_wr) |=> !halted);
  p_rst_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (page != 2'd0 && reg_addr != ADDR_W'(OFS_CMD)) |-> reg_rdata == 8'h00);
endmodule

// File: tb/nic_cmd_irq_tb.sv
module nic_cmd_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_busy = 1'b0, rx_busy = 1'b0, tx_end = 1'b0, ring_pop = 1'b0;
  logic [6:0] evt_in = '0;
  logic       irq, halted, tx_req, dma_go, dma_abort;
  logic [2:0] dma_op;
  logic [1:0] page;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  nic_cmd_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .tx_end(tx_end), .ring_pop(ring_pop), .evt_in(evt_in),
    .irq(irq), .halted(halted), .tx_req(tx_req), .dma_op(dma_op),
    .dma_go(dma_go), .dma_abort(dma_abort), .page(page)
  );

  // reference model, built from the requirements
  logic [1:0] m_st;      // 0 run, 1 drain, 2 halt
  logic       m_ovw, m_txp, m_go, m_ab;
  logic [2:0] m_dma;
  logic [1:0] m_page;
  logic [6:0] m_stat, m_mask;

  logic t_cmd, t_stat, t_mask, t_stop, t_start, t_idle;
  assign t_cmd   = reg_wr && reg_addr == 4'd0;
  assign t_stat  = reg_wr && reg_addr == 4'd1 && m_page == 2'd0;
  assign t_mask  = reg_wr && reg_addr == 4'd2 && m_page == 2'd0;
  assign t_stop  = t_cmd && reg_wdata[0];
  assign t_start = t_cmd && reg_wdata[1] && !reg_wdata[0];
  assign t_idle  = !tx_busy && !rx_busy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 2; m_ovw <= 0; m_txp <= 0; m_go <= 0; m_ab <= 0;
      m_dma <= 3'b100; m_page <= 0; m_stat <= 0; m_mask <= 0;
    end else begin
      if (t_stop)                    m_st <= (t_idle || m_st == 2) ? 2'd2 : 2'd1;
      else if (t_start)              m_st <= 0;
      else if (m_st == 1 && t_idle)  m_st <= 2;
      m_ovw <= evt_in[4] ? 1'b1 : ((t_start || ring_pop) ? 1'b0 : m_ovw);
      m_txp <= (t_cmd && reg_wdata[2]) ? 1'b1 : (tx_end ? 1'b0 : m_txp);
      if (t_cmd && reg_wdata[5:3] != 0) m_dma <= reg_wdata[5:3];
      m_go <= t_cmd && (reg_wdata[5:3] == 1 || reg_wdata[5:3] == 2 || reg_wdata[5:3] == 3);
      m_ab <= t_cmd && reg_wdata[5];
      if (t_cmd && reg_wdata[7:6] != 2'b11) m_page <= reg_wdata[7:6];
      m_stat <= evt_in | (m_stat & ~(t_stat ? reg_wdata[6:0] : 7'h0));
      if (t_mask) m_mask <= reg_wdata[6:0];
    end
  end

  function automatic [7:0] exp_rd(input [3:0] a);
    if (a == 0) return {m_page, m_dma, m_txp, m_st == 0, m_st != 0};
    if (m_page == 0 && a == 1) return {(m_st == 2) || m_ovw, m_stat};
    if (m_page == 0 && a == 2) return {1'b0, m_mask};
    return 8'h00;
  endfunction

  function automatic string rd_tag(input [3:0] a);
    if (a == 0) return "R2";
    if (m_page != 0 || a > 2) return "R12";
    return (a == 1) ? "R8" : "R10";
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_outs();
    chk("R11 irq", irq, |(m_stat & m_mask));
    chk("R2 halted", halted, m_st == 2);
    chk("R5 tx_req", tx_req, m_txp);
    chk("R6 dma_op", dma_op, m_dma);
    chk("R6 dma_go", dma_go, m_go);
    chk("R6 dma_abort", dma_abort, m_ab);
    chk("R7 page", page, m_page);
  endtask

  // apply inputs at the falling edge, check the read path, take one edge, check outputs
  task automatic tick(input bit w, input [3:0] a, input [7:0] d, input bit tb, input bit rb,
                      input bit te, input bit rp, input [6:0] ev);
    reg_wr = w; reg_addr = a; reg_wdata = d; tx_busy = tb; rx_busy = rb;
    tx_end = te; ring_pop = rp; evt_in = ev;
    #1;
    chk(rd_tag(a), reg_rdata, exp_rd(a));
    @(posedge clk);
    @(negedge clk);
    chk_outs();
  endtask

  task automatic wr(input [3:0] a, input [7:0] d);
    tick(1, a, d, tx_busy, rx_busy, 0, 0, 0);
  endtask

  task automatic idle(input bit tb, input bit rb);
    tick(0, reg_addr, 8'h00, tb, rb, 0, 0, 0);
  endtask

  task automatic peek(input [3:0] a, output [7:0] v);
    reg_wr = 0; reg_addr = a; #1; v = reg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    @(negedge clk); @(negedge clk);
    peek(0, v); chk("R1 cmd reset", v, 8'h21);
    peek(1, v); chk("R1 status reset", v, 8'h80);
    peek(2, v); chk("R1 mask reset", v, 8'h00);
    chk("R1 halted", halted, 1); chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // start clears bit 7
    wr(0, 8'h02);
    peek(1, v); chk("R3 start clears bit7", v, 8'h00);
    chk("R3 running", halted, 0);
    // stop while busy drains
    tick(1, 0, 8'h01, 1, 0, 0, 0, 0);
    idle(1, 1); idle(0, 1);
    chk("R2 still draining", halted, 0);
    peek(0, v); chk("R2 drain cmd bits", v[1:0], 2'b01);
    idle(0, 0);
    chk("R2 halts when idle", halted, 1);
    // stop and start together: stop wins
    wr(0, 8'h03);
    chk("R3 stop priority", halted, 1);
    wr(0, 8'h02);
    // overwrite and recovery
    tick(0, 1, 8'h00, 0, 0, 0, 0, 7'h10);
    peek(1, v); chk("R4 ovw sets bit7", v, 8'h90);
    wr(1, 8'hFF);
    peek(1, v); chk("R4 bit7 read-only, R9 w1c", v, 8'h80);
    tick(0, 1, 8'h00, 0, 0, 0, 1, 0);
    peek(1, v); chk("R4 ring_pop clears", v, 8'h00);
    // start and overwrite in the same cycle
    tick(1, 0, 8'h02, 0, 0, 0, 0, 7'h10);
    peek(1, v); chk("R4 ovw wins over start", v[7], 1);
    tick(0, 1, 8'h00, 0, 0, 0, 1, 0);
    // transmit request
    wr(0, 8'h04); chk("R5 set", tx_req, 1);
    wr(0, 8'h00); chk("R5 write 0 keeps", tx_req, 1);
    tick(1, 0, 8'h04, 0, 0, 1, 0, 0); chk("R5 set wins", tx_req, 1);
    tick(0, 0, 8'h00, 0, 0, 1, 0, 0); chk("R5 end clears", tx_req, 0);
    // dma codes
    wr(0, 8'h10); chk("R6 write code", dma_op, 3'b010); chk("R6 go", dma_go, 1);
    wr(0, 8'h00); chk("R6 illegal ignored", dma_op, 3'b010); chk("R6 no go", dma_go, 0);
    wr(0, 8'h38); chk("R6 abort", dma_abort, 1);
    // pages
    wr(0, 8'h40); chk("R7 page1", page, 1);
    wr(0, 8'hC0); chk("R7 reserved kept", page, 1);
    tick(0, 0, 8'h00, 0, 0, 0, 0, 7'h01);
    wr(1, 8'h7F);
    peek(2, v); chk("R12 page1 read zero", v, 8'h00);
    wr(0, 8'h00);
    peek(1, v); chk("R12 write off page0 ignored", v[0], 1);
    // mask and irq
    wr(2, 8'hFF);
    peek(2, v); chk("R10 mask bit7 zero", v, 8'h7F);
    chk("R11 irq on", irq, 1);
    tick(1, 1, 8'h01, 0, 0, 0, 0, 7'h01);
    peek(1, v); chk("R9 event beats clear", v[0], 1);
    wr(1, 8'h7F); chk("R11 irq off", irq, 0);
    tick(0, 1, 8'h00, 0, 0, 0, 0, 7'h40);
    chk("R8 dma done bit6", irq, 1);

    // constrained random
    begin
      bit tb = 0, rb = 0;
      void'($urandom(32'h5EED));
      for (int i = 0; i < 4000; i++) begin
        bit w;
        logic [3:0] a;
        logic [7:0] d;
        logic [6:0] ev;
        if ($urandom_range(7) == 0) tb = ~tb;
        if ($urandom_range(7) == 0) rb = ~rb;
        w  = ($urandom_range(3) == 0);
        a  = ($urandom_range(5) == 0) ? 4'($urandom_range(15)) : 4'($urandom_range(2));
        d  = 8'($urandom);
        if (a == 0 && $urandom_range(1) == 0) d[7:6] = 2'b00;
        ev = 7'($urandom) & 7'($urandom) & 7'($urandom);
        tick(w, a, d, tb, rb, $urandom_range(5) == 0, $urandom_range(5) == 0, ev);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule